// File: doc/BRIEF.md
# Dual-Channel Converter Chained Serial Readout Sequencer

This block runs a two-channel sampling analog-to-digital converter from the host side. The converter's conversion-start and chip-select inputs are wired together, so one active-low select line does both jobs. Each falling edge of that line starts a new conversion and also opens a readout window. In that window the converter shifts out the result of the *previous* conversion. The sequencer produces this select strobe at a programmable rate and parks the serial clock high before every strobe fall. It then issues exactly 39 serial clock pulses and shifts in a single data line. That line carries channel 0's word followed at once by channel 1's word.

After each complete frame, the two 14-bit results are presented together with a one-cycle valid pulse. The converter must already be configured for chained output. Because a frame always carries the previous sample, the first frame after any start from idle carries no usable data. That frame is discarded.

The programmed period is clamped to a floor. The floor covers the converter's maximum sample rate and the length of the serial burst. Because of this floor, conversion is always finished by the next strobe fall, and no busy input is needed.

Top module: `adc_chain_reader`

## Requirements
- R1: While reset is low, and in the first cycle after it, `adc_sel_n` and `sclk` are 1, `data_valid` is 0, and both result words are 0.
- R2: Cycle t=0 of a frame is the first cycle in which `adc_sel_n` is 0. In idle, `enable` sampled high at a clock edge makes that edge start t=0. `adc_sel_n` stays 0 for t < 80·HALF, where HALF = SCLK_DIV/2, and is 1 from t = 80·HALF on.
- R3: The period P is latched at every strobe fall. P = `period` when `period` ≥ FLOOR, and P = FLOOR otherwise. FLOOR is the larger of MIN_PERIOD and 80·HALF+1 (108 with the defaults). A frame lasts P cycles, and the next frame's t=0 follows right after.
- R4: `sclk` is 1 in the cycle where `adc_sel_n` falls, and it is 1 whenever `adc_sel_n` is 1.
- R5: Each frame holds exactly 39 serial clock pulses. With h = t/HALF (integer division), `sclk` is 0 exactly when h is odd and h < 78.
- R6: `sdo` is sampled at each rising edge of `sclk`. The j-th rising edge (j from 0) gives frame bit j. Channel 0 is frame bits 1..14 and channel 1 is frame bits 16..29, both MSB first.
- R7: `data_valid` is high for exactly one cycle, at t = 78·HALF, and both words change in that same cycle. At all other times the words hold their values.
- R8: The frame that follows strobe fall k carries the sample started at fall k−1. The first frame after reset, and after any return to idle, gives no `data_valid`.
- R9: When `enable` is low at the last cycle of a frame, the sequencer goes idle. `adc_sel_n` and `sclk` then stay 1 until `enable` is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; checked at frame boundaries |
| period | input | PERIOD_W | Frame period in system clocks (clamped to FLOOR) |
| sdo | input | 1 | Chained serial data from the converter |
| adc_sel_n | output | 1 | Shared conversion-start / chip-select strobe, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| ch0_data | output | DATA_W | Channel 0 result of the last valid frame |
| ch1_data | output | DATA_W | Channel 1 result of the last valid frame |
| data_valid | output | 1 | One-cycle pulse when both words update |

## Verification
All outputs come from registers, so every result falls on a known cycle offset t counted from the strobe fall. The strobe falls on the edge that samples `enable`. The clock level follows from t/HALF. The result words and the valid pulse are due at t = 78·HALF, on the same edge that captures the 39th data bit. The data are those of the conversion two strobe falls back, as seen by a behavioural converter model. The bench predicts every output for each cycle from an integer frame counter and compares it half a clock after each edge, so each result is checked in the exact cycle it is due and no other.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

    function automatic int unsigned rd_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
    parameter int unsigned HALF = 1,
    parameter int unsigned BITS = 39
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic sclk_o,
    output logic rise_o,
    output logic last_o,
    output logic release_o
);
    localparam int unsigned PH_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned HREL = 2 * (BITS + 1);
    localparam int unsigned H_W  = $clog2(HREL + 1);
    localparam int unsigned R_W  = $clog2(BITS + 2);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic [H_W-1:0]  h;
        logic            sclk;
    } cg_t;

    cg_t cg_d, cg_q;

    always_comb begin
        cg_d = cg_q;
        if (restart_i) begin
            cg_d.ph = '0;
            cg_d.h  = '0;
        end else if (cg_q.h != H_W'(HREL)) begin
            if (cg_q.ph == PH_W'(HALF - 1)) begin
                cg_d.ph = '0;
                cg_d.h  = cg_q.h + 1'b1;
            end else begin
                cg_d.ph = cg_q.ph + 1'b1;
            end
        end
        // low on odd half-periods inside the burst, high otherwise
        cg_d.sclk = !(cg_d.h[0] && (cg_d.h < H_W'(2 * BITS)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cg_q.ph   <= '0;
            cg_q.h    <= H_W'(HREL);
            cg_q.sclk <= 1'b1;
        end else begin
            cg_q <= cg_d;
        end
    end

    assign sclk_o    = cg_q.sclk;
    assign rise_o    = !cg_q.sclk && cg_d.sclk;
    assign last_o    = rise_o && (cg_d.h == H_W'(2 * BITS));
    assign release_o = (cg_q.h == H_W'(HREL - 1)) && (cg_q.ph == PH_W'(HALF - 1));

    logic [R_W-1:0] rises_q;
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) rises_q <= '0;
        else if (rise_o)         rises_q <= rises_q + 1'b1;
    end

    // R5
    max_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= R_W'(BITS));

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
    parameter int unsigned FRAME_BITS = 39,
    parameter int unsigned DATA_W     = 14,
    parameter int unsigned POS0       = 1,
    parameter int unsigned POS1       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              last_i,
    input  logic              keep_i,
    input  logic              sdo_i,
    output logic [DATA_W-1:0] ch0_o,
    output logic [DATA_W-1:0] ch1_o,
    output logic              valid_o
);
    localparam int unsigned HI0 = FRAME_BITS - 1 - POS0;
    localparam int unsigned HI1 = FRAME_BITS - 1 - POS1;

    typedef struct packed {
        logic [FRAME_BITS-1:0] shift;
        logic [DATA_W-1:0]     ch0;
        logic [DATA_W-1:0]     ch1;
        logic                  valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = 1'b0;
        if (sample_i) cap_d.shift = {cap_q.shift[FRAME_BITS-2:0], sdo_i};
        if (last_i && keep_i) begin
            cap_d.ch0   = cap_d.shift[HI0 -: DATA_W];
            cap_d.ch1   = cap_d.shift[HI1 -: DATA_W];
            cap_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign ch0_o   = cap_q.ch0;
    assign ch1_o   = cap_q.ch1;
    assign valid_o = cap_q.valid;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.valid |=> !cap_q.valid);

    // R7
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_q.valid |-> (cap_q.ch0 == $past(cap_q.ch0)) || !$past(rst_n));

endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned DATA_W     = 14,
    parameter int unsigned FRAME_BITS = 39,
    parameter int unsigned CH0_POS    = 1,
    parameter int unsigned CH1_POS    = 16,
    parameter int unsigned SCLK_DIV   = 2,   // even, at least 2
    parameter int unsigned MIN_PERIOD = 108, // system clocks per fastest conversion
    parameter int unsigned PERIOD_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic                sdo,
    output logic                adc_sel_n,
    output logic                sclk,
    output logic [DATA_W-1:0]   ch0_data,
    output logic [DATA_W-1:0]   ch1_data,
    output logic                data_valid
);
    localparam int unsigned HALF  = SCLK_DIV / 2;
    localparam int unsigned SPAN  = 2 * (FRAME_BITS + 1) * HALF;
    localparam int unsigned FLOOR = rd_max(MIN_PERIOD, SPAN + 1);
    localparam int unsigned GAP_W = PERIOD_W + 1;

    typedef struct packed {
        rd_state_e           state;
        logic [PERIOD_W-1:0] cnt;
        logic [PERIOD_W-1:0] lim;
        logic                first;
        logic                sel_n;
    } seq_t;

    seq_t seq_d, seq_q;
    logic restart;
    logic rise, last, release_sel;

    always_comb begin
        seq_d   = seq_q;
        restart = 1'b0;
        case (seq_q.state)
            RD_IDLE: begin
                if (enable) begin
                    restart     = 1'b1;
                    seq_d.state = RD_RUN;
                    seq_d.first = 1'b1;
                end
            end
            default: begin
                if (seq_q.cnt == seq_q.lim - 1'b1) begin
                    if (enable) begin
                        restart     = 1'b1;
                        seq_d.first = 1'b0;
                    end else begin
                        seq_d.state = RD_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
        endcase
        if (restart) begin
            seq_d.cnt   = '0;
            seq_d.lim   = (period < PERIOD_W'(FLOOR)) ? PERIOD_W'(FLOOR) : period;
            seq_d.sel_n = 1'b0;
        end else if (release_sel) begin
            seq_d.sel_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= RD_IDLE;
            seq_q.cnt   <= '0;
            seq_q.lim   <= PERIOD_W'(FLOOR);
            seq_q.first <= 1'b1;
            seq_q.sel_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    adc_rd_clkgen #(
        .HALF (HALF),
        .BITS (FRAME_BITS)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .sclk_o    (sclk),
        .rise_o    (rise),
        .last_o    (last),
        .release_o (release_sel)
    );

    adc_rd_capture #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_W     (DATA_W),
        .POS0       (CH0_POS),
        .POS1       (CH1_POS)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (rise),
        .last_i   (last),
        .keep_i   (!seq_q.first),
        .sdo_i    (sdo),
        .ch0_o    (ch0_data),
        .ch1_o    (ch1_data),
        .valid_o  (data_valid)
    );

    assign adc_sel_n = seq_q.sel_n;

    // strobe spacing monitor
    logic             sel_prev_q, seen_q;
    logic [GAP_W-1:0] gap_q;
    logic             sel_fall;
    assign sel_fall = sel_prev_q && !adc_sel_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev_q <= 1'b1;
            seen_q     <= 1'b0;
            gap_q      <= '0;
        end else begin
            sel_prev_q <= adc_sel_n;
            if (sel_fall) begin
                seen_q <= 1'b1;
                gap_q  <= GAP_W'(1);
            end else if (gap_q != '1) begin
                gap_q  <= gap_q + 1'b1;
            end
        end
    end

    // R3
    min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fall && seen_q) |-> (gap_q >= GAP_W'(FLOOR)));

    // R4
    sclk_high_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sel_n) |-> sclk);

    // R4
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sel_n |-> sclk);

    // R8
    no_valid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.first && seq_q.state == RD_RUN) |-> !data_valid);

endmodule

// File: tb/tb_adc_chain_reader.sv
module tb_adc_chain_reader;
    localparam int DW    = 14;
    localparam int PW    = 12;
    localparam int DIV   = 2;
    localparam int HF    = DIV / 2;
    localparam int MINP  = 108;
    localparam int SPAN  = 80 * HF;
    localparam int FLOOR = (MINP > SPAN + 1) ? MINP : SPAN + 1;
    localparam int TV    = 78 * HF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [PW-1:0] period = PW'(150);
    logic          sdo = 1'b0;
    logic          adc_sel_n, sclk, data_valid;
    logic [DW-1:0] ch0_data, ch1_data;

    always #5 clk = ~clk;

    adc_chain_reader dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period), .sdo(sdo),
        .adc_sel_n(adc_sel_n), .sclk(sclk), .ch0_data(ch0_data),
        .ch1_data(ch1_data), .data_valid(data_valid)
    );

    int nvec = 0;
    int nmis = 0;

    function automatic logic [DW-1:0] f0(input int n);
        return DW'((n * 1237 + 91) & 16383);
    endfunction
    function automatic logic [DW-1:0] f1(input int n);
        return DW'((16383 - ((n * 733) & 16383)) ^ 5461);
    endfunction

    // behavioural converter: new sample at strobe fall, previous one shifted out
    logic [DW-1:0] cur0 = '0, cur1 = '0, out0 = '0, out1 = '0;
    int aconv = 0;
    int aidx = -1;

    function automatic logic frame_bit(input int j, input logic [DW-1:0] a, input logic [DW-1:0] b);
        if (j >= 1 && j <= 14)  return a[14 - j];
        if (j >= 16 && j <= 29) return b[29 - j];
        return 1'b0;
    endfunction

    always @(negedge adc_sel_n or negedge sclk) begin
        if (sclk == 1'b1) begin
            out0 = cur0; out1 = cur1;
            cur0 = f0(aconv); cur1 = f1(aconv);
            aconv++;
            aidx = -1;
            sdo = 1'b0;
        end else if (adc_sel_n == 1'b0) begin
            aidx++;
            sdo = (aidx < 39) ? frame_bit(aidx, out0, out1) : 1'b0;
        end
    end

    // cycle reference model
    bit m_idle = 1'b1, m_first = 1'b1, m_rst = 1'b1, started = 1'b0;
    int t = 0, lim = FLOOR, conv = 0;
    logic [DW-1:0] e0 = '0, e1 = '0;

    function automatic int clampf(input int p);
        return (p < FLOOR) ? FLOOR : p;
    endfunction

    always @(posedge clk) begin
        m_rst = !rst_n;
        if (!rst_n) begin
            m_idle = 1'b1; m_first = 1'b1; t = 0; e0 = '0; e1 = '0;
        end else if (m_idle) begin
            if (enable) begin
                m_idle = 1'b0; t = 0; lim = clampf(int'(period)); m_first = 1'b1; conv++;
            end
        end else if (t == lim - 1) begin
            if (enable) begin
                t = 0; lim = clampf(int'(period)); m_first = 1'b0; conv++;
            end else begin
                m_idle = 1'b1;
            end
        end else begin
            t++;
        end
        if (!m_idle && t == TV && !m_first) begin
            e0 = f0(conv - 2); e1 = f1(conv - 2);
        end
        started = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nmis++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    logic x_sel, x_sclk, x_val;
    always @(negedge clk) begin
        if (started) begin
            x_sel  = m_idle ? 1'b1 : !(t < SPAN);
            x_sclk = m_idle ? 1'b1 : !(((t / HF) % 2 == 1) && (t / HF) < 78);
            x_val  = !m_idle && t == TV && !m_first;
            if (m_rst) begin
                chk(adc_sel_n === 1'b1 && sclk === 1'b1 && data_valid === 1'b0,
                    "R1 reset outputs", {adc_sel_n, sclk, data_valid}, 3'b110);
                chk(ch0_data === '0 && ch1_data === '0, "R1 reset words",
                    int'(ch0_data), 0);
            end else begin
                chk(adc_sel_n === x_sel, "R2 R3 R9 strobe", adc_sel_n, x_sel);
                chk(sclk === x_sclk, "R4 R5 serial clock", sclk, x_sclk);
                chk(data_valid === x_val, "R7 R8 valid pulse", data_valid, x_val);
                chk(ch0_data === e0, "R6 channel 0 word", int'(ch0_data), int'(e0));
                chk(ch1_data === e1, "R6 channel 1 word", int'(ch1_data), int'(e1));
            end
        end
    end

    // R5: pulses per frame counted at the pins
    int pulses = 0;
    always @(posedge sclk) if (adc_sel_n == 1'b0) pulses++;
    always @(posedge adc_sel_n) begin
        if (started && rst_n) begin
            chk(pulses == 39, "R5 pulses per frame", pulses, 39);
        end
        pulses = 0;
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nmis++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        enable = 1'b1;                       // R2 start, period 150
        repeat (760) @(negedge clk);
        period = PW'(10);                    // R3 clamped to FLOOR
        repeat (600) @(negedge clk);
        period = PW'(333);
        repeat (700) @(negedge clk);
        enable = 1'b0;                       // R9 finish and idle
        repeat (500) @(negedge clk);
        period = PW'(120);
        enable = 1'b1;                       // R8 first frame discarded again
        repeat (400) @(negedge clk);
        period = PW'(FLOOR);
        repeat (350) @(negedge clk);
        enable = 1'b0;
        repeat (300) @(negedge clk);
        finish_run();
    end

endmodule